// File: doc/BRIEF.md
# Quantized Multiply-Accumulate Lane Array

This block is a row of identical arithmetic lanes for low-precision neural-network inference. Each cycle that the operand strobe is high, every lane takes one unsigned 8-bit value from each of two input vectors. It removes a shared zero point from each value, which gives a signed 9-bit number. The lane then runs the commanded operation on its private 32-bit accumulator: a saturating multiply-accumulate, a minimum, a maximum, a clear, or no operation.

Eight predicate registers hold one bit per lane. A command can name one of them so that only the lanes whose bit is set change their accumulator. The same command can also rewrite any predicate register from a sign test on each lane's updated accumulator. The next command can then act only on the lanes whose results were positive, negative, zero or nonzero.

Results are registered. Accumulators and the result strobe change on the clock edge that samples the command. The lane count defaults to 16.

Top module: `qmac_lane_array`

## Requirements
- R1: In each lane, an operand byte and its zero point are both unsigned 8-bit values. The corrected value is their difference, taken as a signed 9-bit number (range -255..+255), and all arithmetic uses this value.
- R2: Command code 1 (multiply-accumulate) adds the product of the two corrected values to the accumulator. Command code 0 (no operation) leaves every accumulator unchanged.
- R3: A multiply-accumulate whose true sum exceeds the signed 32-bit range stores +2147483647 if the true sum is positive and -2147483648 if it is negative. The accumulator does not wrap.
- R4: Command code 2 stores the smaller of the two corrected values, and command code 3 stores the larger. The stored value is sign-extended to 32 bits.
- R5: Command code 4 sets the accumulator of every enabled lane to zero in a single cycle.
- R6: Accumulators change only on a clock edge where `op_valid` is high. `res_valid` is high in exactly the cycle that follows each such edge.
- R7: When `pred_en` is high, only the lanes whose bit is set in the predicate register chosen by `pred_sel` update. All other lanes hold their accumulators.
- R8: When `op_valid` and `pred_wr_en` are both high, predicate register `pred_wr_sel` is rewritten with, for each lane, a test of that lane's updated accumulator against zero. The `pred_cond` codes are 0 = greater than, 1 = less than, 2 = equal and 3 = not equal. The other predicate registers keep their contents.
- R9: Reset clears every accumulator and `res_valid`, and sets every bit of every predicate register.
- R10: `pred_view` always shows the contents of the predicate register chosen by `pred_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Command and operands are present this cycle |
| op_code | input | 3 | Command: 0 none, 1 multiply-accumulate, 2 minimum, 3 maximum, 4 clear |
| a_vec | input | LANES*8 | First operand, one byte per lane, with lane 0 in the low byte |
| b_vec | input | LANES*8 | Second operand, one byte per lane |
| a_zero | input | 8 | Zero point subtracted from every byte of `a_vec` |
| b_zero | input | 8 | Zero point subtracted from every byte of `b_vec` |
| pred_en | input | 1 | Restrict updates to lanes enabled by a predicate register |
| pred_sel | input | 3 | Predicate register used for restricting updates and for `pred_view` |
| pred_wr_en | input | 1 | Rewrite a predicate register from this command's results |
| pred_wr_sel | input | 3 | Predicate register to rewrite |
| pred_cond | input | 2 | Comparison against zero used for the rewrite |
| acc_out | output | LANES*32 | Accumulators, with lane 0 in the low word |
| res_valid | output | 1 | Accumulators reflect the command of the previous cycle |
| pred_view | output | LANES | Contents of predicate register `pred_sel` |

## Verification
A wrong zero-point correction or a wrong product shows up on `acc_out` one cycle after the command that caused it. Because the accumulators keep the error, every later check on that lane shows it too. A saturation fault appears on the first multiply-accumulate that crosses a 32-bit limit, as a wrapped value of the opposite sign. A corrupt predicate register shows up immediately on `pred_view`. It also shows up one cycle after the next predicated command, when a lane that should have held its value has changed, or the reverse.

// File: rtl/qmac_pkg.sv
package qmac_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_MAC = 3'd1,
        OP_MIN = 3'd2,
        OP_MAX = 3'd3,
        OP_CLR = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        CMP_GT = 2'd0,
        CMP_LT = 2'd1,
        CMP_EQ = 2'd2,
        CMP_NE = 2'd3
    } cmp_e;

endpackage

// File: rtl/qmac_lane.sv
module qmac_lane
    import qmac_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic [2:0]           op,
    input  logic [DW-1:0]        a,
    input  logic [DW-1:0]        b,
    input  logic [DW-1:0]        za,
    input  logic [DW-1:0]        zb,
    output logic signed [AW-1:0] acc_q,
    output logic signed [AW-1:0] acc_nx
);
    localparam int SW = DW + 1;
    localparam int PW = 2 * SW;

    logic signed [SW-1:0] sa, sb, pick;
    logic signed [PW-1:0] prod;
    logic signed [AW:0]   sum;
    logic signed [AW-1:0] cand;

    assign sa   = $signed({1'b0, a}) - $signed({1'b0, za});
    assign sb   = $signed({1'b0, b}) - $signed({1'b0, zb});
    assign prod = sa * sb;
    assign sum  = {acc_q[AW-1], acc_q} + {{(AW+1-PW){prod[PW-1]}}, prod};

    always_comb begin
        pick = sa;
        cand = acc_q;
        unique case (op_e'(op))
            OP_MAC: begin
                if (sum[AW] != sum[AW-1])
                    cand = sum[AW] ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}};
                else
                    cand = sum[AW-1:0];
            end
            OP_MIN: begin
                pick = (sa < sb) ? sa : sb;
                cand = {{(AW-SW){pick[SW-1]}}, pick};
            end
            OP_MAX: begin
                pick = (sa > sb) ? sa : sb;
                cand = {{(AW-SW){pick[SW-1]}}, pick};
            end
            OP_CLR:  cand = '0;
            default: cand = acc_q;
        endcase
    end

    assign acc_nx = upd ? cand : acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_nx;
    end

endmodule

// File: rtl/qmac_pred_file.sv
module qmac_pred_file
    import qmac_pkg::*;
#(
    parameter int LANES = 16,
    parameter int NPRED = 8,
    parameter int AW    = 32,
    localparam int SELW = $clog2(NPRED)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr,
    input  logic [SELW-1:0]              wsel,
    input  logic [1:0]                   cond,
    input  logic [LANES*AW-1:0]          nxt,
    output logic [NPRED-1:0][LANES-1:0]  pred_q
);
    logic [LANES-1:0] flag;

    for (genvar i = 0; i < LANES; i++) begin : g_cmp
        logic signed [AW-1:0] v;
        assign v = $signed(nxt[i*AW +: AW]);
        always_comb begin
            unique case (cmp_e'(cond))
                CMP_GT:  flag[i] = (v > 0);
                CMP_LT:  flag[i] = v[AW-1];
                CMP_EQ:  flag[i] = (v == 0);
                default: flag[i] = (v != 0);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  pred_q       <= '1;
        else if (wr) pred_q[wsel] <= flag;
    end

endmodule

// File: rtl/qmac_lane_array.sv
module qmac_lane_array
    import qmac_pkg::*;
#(
    parameter int LANES = 16,
    parameter int DW    = 8,
    parameter int AW    = 32,
    parameter int NPRED = 8,
    localparam int SELW = $clog2(NPRED)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid,
    input  logic [2:0]            op_code,
    input  logic [LANES*DW-1:0]   a_vec,
    input  logic [LANES*DW-1:0]   b_vec,
    input  logic [DW-1:0]         a_zero,
    input  logic [DW-1:0]         b_zero,
    input  logic                  pred_en,
    input  logic [SELW-1:0]       pred_sel,
    input  logic                  pred_wr_en,
    input  logic [SELW-1:0]       pred_wr_sel,
    input  logic [1:0]            pred_cond,
    output logic [LANES*AW-1:0]   acc_out,
    output logic                  res_valid,
    output logic [LANES-1:0]      pred_view
);
    logic [NPRED-1:0][LANES-1:0] pred_all;
    logic [LANES*AW-1:0]         acc_next;
    logic [LANES-1:0]            gate;

    assign pred_view = pred_all[pred_sel];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign gate[i] = !pred_en || pred_all[pred_sel][i];

        qmac_lane #(.DW(DW), .AW(AW)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .upd    (op_valid && gate[i]),
            .op     (op_code),
            .a      (a_vec[i*DW +: DW]),
            .b      (b_vec[i*DW +: DW]),
            .za     (a_zero),
            .zb     (b_zero),
            .acc_q  (acc_out[i*AW +: AW]),
            .acc_nx (acc_next[i*AW +: AW])
        );
    end

    qmac_pred_file #(.LANES(LANES), .NPRED(NPRED), .AW(AW)) u_pred (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (op_valid && pred_wr_en),
        .wsel   (pred_wr_sel),
        .cond   (pred_cond),
        .nxt    (acc_next),
        .pred_q (pred_all)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_valid <= 1'b0;
        else        res_valid <= op_valid;
    end

endmodule

// File: rtl/qmac_chk.sv
module qmac_chk #(
    parameter int LANES = 16,
    parameter int DW    = 8,
    parameter int AW    = 32,
    parameter int NPRED = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        op_valid,
    input logic [2:0]                  op_code,
    input logic                        pred_en,
    input logic                        pred_wr_en,
    input logic                        res_valid,
    input logic [LANES*AW-1:0]         acc_out,
    input logic [NPRED-1:0][LANES-1:0] pred_all
);
    localparam int LIM = (1 << DW) - 1;

    AST_RES_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);  // R6
    AST_RES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid);  // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(acc_out));  // R6
    AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd0) |=> $stable(acc_out));  // R2
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd4 && !pred_en) |=> (acc_out == '0));  // R5
    AST_PRED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && pred_wr_en) |=> $stable(pred_all));  // R8

    for (genvar i = 0; i < LANES; i++) begin : g_rng
        logic signed [AW-1:0] v;
        assign v = $signed(acc_out[i*AW +: AW]);
        AST_MINMAX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && !pred_en && (op_code == 3'd2 || op_code == 3'd3))
            |=> (v >= -LIM && v <= LIM));  // R4
    end

endmodule

bind qmac_lane_array qmac_chk #(
    .LANES(LANES), .DW(DW), .AW(AW), .NPRED(NPRED)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .pred_en    (pred_en),
    .pred_wr_en (pred_wr_en),
    .res_valid  (res_valid),
    .acc_out    (acc_out),
    .pred_all   (pred_all)
);

// File: tb/sim_qmac_lane_array.sv
module sim_qmac_lane_array;
    localparam int L = 16;
    localparam int NV = 10;
    // {op, a, b, a_zero, b_zero}
    localparam logic [34:0] VEC [0:NV-1] = '{
        {3'd4, 8'd0,   8'd0,   8'd0,   8'd0},
        {3'd1, 8'd10,  8'd20,  8'd0,   8'd0},
        {3'd1, 8'd200, 8'd3,   8'd128, 8'd1},
        {3'd2, 8'd5,   8'd250, 8'd0,   8'd128},
        {3'd3, 8'd5,   8'd250, 8'd0,   8'd128},
        {3'd1, 8'd0,   8'd0,   8'd255, 8'd255},
        {3'd0, 8'd77,  8'd99,  8'd3,   8'd4},
        {3'd3, 8'd255, 8'd0,   8'd0,   8'd0},
        {3'd1, 8'd128, 8'd128, 8'd128, 8'd128},
        {3'd1, 8'd1,   8'd254, 8'd128, 8'd255}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic op_valid = 1'b0, pred_en = 1'b0, pred_wr_en = 1'b0;
    logic [2:0] op_code = '0, pred_sel = '0, pred_wr_sel = '0;
    logic [1:0] pred_cond = '0;
    logic [L*8-1:0] a_vec = '0, b_vec = '0;
    logic [7:0] a_zero = '0, b_zero = '0;
    logic [L*32-1:0] acc_out;
    logic res_valid;
    logic [L-1:0] pred_view;

    longint m [L];
    logic [L-1:0] pm [8];
    int nchk = 0, nfail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    qmac_lane_array u0 (.*);

    function automatic int op_a(int a, int i, bit sp); return sp ? ((a + 7*i) & 255) : a; endfunction
    function automatic int op_b(int b, int i, bit sp); return sp ? ((b ^ (11*i)) & 255) : b; endfunction

    task automatic chk(string tag, longint act, longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_lanes(string tag);
        for (int i = 0; i < L; i++)
            chk(tag, longint'($signed(acc_out[i*32 +: 32])), m[i]);
    endtask

    task automatic do_op(int op, int a, int b, int za, int zb, bit sp,
                         bit pe, int ps, bit pw, int ws, int cnd);
        logic [L-1:0] gate, nf;
        @(negedge clk);
        op_valid = 1; op_code = 3'(op); a_zero = 8'(za); b_zero = 8'(zb);
        pred_en = pe; pred_sel = 3'(ps); pred_wr_en = pw; pred_wr_sel = 3'(ws);
        pred_cond = 2'(cnd);
        for (int i = 0; i < L; i++) begin
            a_vec[i*8 +: 8] = 8'(op_a(a, i, sp));
            b_vec[i*8 +: 8] = 8'(op_b(b, i, sp));
        end
        gate = pe ? pm[ps] : '1;
        for (int i = 0; i < L; i++) begin
            longint sa, sb, s;
            sa = op_a(a, i, sp) - za;
            sb = op_b(b, i, sp) - zb;
            if (gate[i]) begin
                case (op)
                    1: begin
                        s = m[i] + sa * sb;
                        if (s > 64'sd2147483647) s = 64'sd2147483647;
                        if (s < -64'sd2147483648) s = -64'sd2147483648;
                        m[i] = s;
                    end
                    2: m[i] = (sa < sb) ? sa : sb;
                    3: m[i] = (sa > sb) ? sa : sb;
                    4: m[i] = 0;
                    default: ;
                endcase
            end
            case (cnd)
                0: nf[i] = m[i] > 0;
                1: nf[i] = m[i] < 0;
                2: nf[i] = m[i] == 0;
                default: nf[i] = m[i] != 0;
            endcase
        end
        if (pw) pm[ws] = nf;
        @(negedge clk);
        op_valid = 0; pred_wr_en = 0; pred_en = 0;
    endtask

    initial begin
        for (int i = 0; i < L; i++) m[i] = 0;
        for (int k = 0; k < 8; k++) pm[k] = '1;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk_lanes("R9 acc after reset");
        chk("R9 res_valid after reset", res_valid, 0);
        rst_n = 1;
        for (int k = 0; k < 8; k++) begin
            pred_sel = 3'(k); #1;
            chk("R9 predicate reset ones", pred_view, {L{1'b1}});
        end

        // Table walk: R1 offsets, R2 MAC/NOP, R4 min/max, R5 clear
        for (int v = 0; v < NV; v++) begin
            do_op(int'(VEC[v][34:32]), int'(VEC[v][31:24]), int'(VEC[v][23:16]),
                  int'(VEC[v][15:8]), int'(VEC[v][7:0]), 1, 0, 0, 0, 0, 0);
            chk("R6 res_valid after command", res_valid, 1);
            chk_lanes("R1 R2 R4 R5 table vector");
        end
        @(negedge clk);
        chk("R6 res_valid idle", res_valid, 0);
        chk_lanes("R6 hold without op_valid");

        // R3: positive saturation
        do_op(4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int n = 0; n < 33030; n++) do_op(1, 255, 255, 0, 0, 0, 0, 0, 0, 0, 0);
        chk_lanes("R3 positive clamp");
        chk("R3 positive clamp value", longint'($signed(acc_out[31:0])), 64'sd2147483647);
        // R3: negative saturation and recovery
        do_op(4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int n = 0; n < 33030; n++) do_op(1, 255, 0, 0, 255, 0, 0, 0, 0, 0, 0);
        chk("R3 negative clamp value", longint'($signed(acc_out[31:0])), -64'sd2147483648);
        do_op(1, 255, 255, 0, 0, 0, 0, 0, 0, 0, 0);
        chk_lanes("R3 leave negative clamp");

        // R8: predicate write, R10: view
        do_op(2, 100, 255, 128, 0, 1, 0, 0, 1, 3, 0);
        chk_lanes("R4 mixed-sign minimum");
        pred_sel = 3'd3; #1;
        chk("R8 GT predicate written", pred_view, pm[3]);
        do_op(0, 0, 0, 0, 0, 0, 0, 0, 1, 5, 1);
        pred_sel = 3'd5; #1;
        chk("R8 LT predicate written", pred_view, pm[5]);
        pred_sel = 3'd3; #1;
        chk("R8 other register kept", pred_view, pm[3]);
        pred_sel = 3'd0; #1;
        chk("R10 untouched register view", pred_view, {L{1'b1}});

        // R7: predicated updates
        do_op(1, 50, 60, 0, 0, 1, 1, 3, 0, 0, 0);
        chk_lanes("R7 predicated MAC");
        do_op(4, 0, 0, 0, 0, 0, 1, 5, 0, 0, 0);
        chk_lanes("R7 R5 predicated clear");
        do_op(3, 0, 0, 0, 0, 0, 0, 0, 1, 6, 2);
        pred_sel = 3'd6; #1;
        chk("R8 EQ predicate", pred_view, pm[6]);
        do_op(1, 200, 9, 0, 0, 1, 1, 6, 1, 7, 3);
        chk_lanes("R7 predicated on EQ");
        pred_sel = 3'd7; #1;
        chk("R8 NE predicate", pred_view, pm[7]);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule